// File: doc/BRIEF.md
# PCI target termination controller

This block sits on the target side of a 32-bit PCI bus interface and decides how every inbound transaction ends. When the address decoder claims a transaction, the block asserts DEVSEL#. It then paces data phases with TRDY# according to a local ready signal. It ends the transaction in one of four ways: normal completion, disconnect, retry or target-abort. It tracks the burst address, the beat count, the attributes of the matched inbound window and the wait time since the last data phase, and it chooses a termination from a fixed set of rules.

The block also keeps the signaled-target-abort flag of the target status word. It cancels inbound writes that carry a parity error on the local side, while the bus handshake still runs to its normal end. Address decoding, configuration space and the local memory interface sit outside the block. They appear only as simple inputs and outputs.

Top module: `pci_tgt_term`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high, `wr_strobe` and `wr_cancel` are low, and `status` is zero.
- R2: A claim is `addr_hit` high with FRAME# low at a clock edge, while the block is idle, with buffer space free and no abort request. After a claim, DEVSEL# goes low on the next clock and TRDY# stays high. TRDY# goes low one clock after `data_ready` is sampled high. A data beat is a clock edge with TRDY# and IRDY# both low. A beat taken with FRAME# high completes the transaction normally, and all three outputs go high on the next clock.
- R3: A claim made while `buf_avail` is low is answered with a retry on the next clock: STOP# and DEVSEL# low, TRDY# high, and no data beat.
- R4: If the first data beat has not started, and 32 clock edges after the claim pass with `data_ready` low, STOP# goes low with DEVSEL# low and TRDY# high. This is a retry.
- R5: After at least one beat, 8 clock edges without a beat and with `data_ready` low cause a disconnect: STOP# low, DEVSEL# low, TRDY# high.
- R6: A non-final beat at an address whose bits 11:2 are all ones (the last word of a 4 KB page) causes a disconnect on the next clock.
- R7: When `win_nonpref` was high at the claim, the block disconnects after the first beat unless that beat is the final one.
- R8: A write claimed with `wrap_mode` high advances its address within a 32-byte line, with no 4 KB page disconnect. It disconnects after the 8th beat unless that beat is final. A read claimed with `wrap_mode` high runs linearly.
- R9: A target-abort drives STOP# low and DEVSEL# and TRDY# high on the clock after `abort_req` is sampled during a claim or transfer. It sets bit 11 of `status`, which stays set until reset.
- R10: Target-abort takes priority over retry. A claim with both `abort_req` high and `buf_avail` low ends in target-abort.
- R11: STOP# stays low while FRAME# is low. On the clock after FRAME# is sampled high, STOP#, DEVSEL# and TRDY# all go high.
- R12: A write with `par_err` sampled high at its claim or during its transfer raises `wr_cancel` until the transaction ends. No `wr_strobe` is issued in that beat or any later beat. The bus handshake and beat count are unchanged.
- R13: `wr_strobe` is high during each clock that ends in a write beat of an uncancelled transaction, and it stays low for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| addr_hit | input | 1 | Decoder claim, valid during the address phase |
| addr | input | ADDR_W | Start address of the transaction |
| is_write | input | 1 | Transaction is a write |
| buf_avail | input | 1 | Inbound buffer space is free |
| win_nonpref | input | 1 | Matched window is non-prefetchable |
| wrap_mode | input | 1 | Cache-wrap transfer mode |
| data_ready | input | 1 | Local side can take or give a beat |
| abort_req | input | 1 | Local side requests target-abort |
| par_err | input | 1 | Address or data parity error seen |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| wr_strobe | output | 1 | Write beat forwarded to the local side |
| wr_cancel | output | 1 | Current write is cancelled internally |
| status | output | 16 | Target status word; bit 11 is signaled target-abort |

## Verification
The block's state shows on the bus pins one clock after the deciding edge. A wrong beat count or address shows as a STOP# that comes one or more beats early or late. A stuck timer shows as a retry or disconnect off its 32- or 8-edge mark, or one that never comes. A wrong cancel or abort flag shows up in the same clock on `wr_strobe`, or on the next clock on DEVSEL# and `status`. The bench therefore counts beats, edges until STOP#, write strobes and release timing for each transaction.

// File: rtl/pci_tgt_term_pkg.sv
package pci_tgt_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_STOP = 2'd2
    } tstate_e;

    // Registered control word of the termination sequencer
    typedef struct packed {
        tstate_e st;
        logic    devsel;
        logic    trdy;
        logic    stop;
        logic    wr;
        logic    np;
        logic    cancel;
        logic    sig_ta;
    } ctl_s;

    // Status-word position decoded by the configuration block
    localparam int unsigned SIG_TA_BIT = 11;
    localparam int unsigned STATUS_W   = 16;

endpackage

// File: rtl/ptt_wait_timer.sv
module ptt_wait_timer #(
    parameter int unsigned FIRST_LIMIT = 32,
    parameter int unsigned NEXT_LIMIT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic first,
    output logic expired
);
    localparam int unsigned MAXL = (FIRST_LIMIT > NEXT_LIMIT) ? FIRST_LIMIT : NEXT_LIMIT;
    localparam int unsigned CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim;

    always_comb begin
        lim     = first ? CW'(FIRST_LIMIT - 1) : CW'(NEXT_LIMIT - 1);
        expired = run && (cnt_q == lim);
        cnt_d   = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != lim)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4 / R5: the count never runs past the longer limit
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAXL));

endmodule

// File: rtl/ptt_burst_track.sv
module ptt_burst_track #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_BITS  = 12,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_wrap,
    input  logic              beat,
    output logic              first_beat,
    output logic              page_last,
    output logic              line_last
);
    localparam int unsigned LL    = $clog2(LINE_BYTES);
    localparam int unsigned WORDS = LINE_BYTES / 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  beats;
        logic              wrap;
    } trk_s;

    trk_s          q, d;
    logic [LL-3:0] off_next;

    always_comb begin
        d        = q;
        off_next = q.addr[LL-1:2] + (LL-2)'(1);
        if (load) begin
            d.addr  = load_addr;
            d.beats = '0;
            d.wrap  = load_wrap;
        end else if (beat) begin
            if (q.wrap) begin
                d.addr = {q.addr[ADDR_W-1:LL], off_next, q.addr[1:0]};
            end else begin
                d.addr = q.addr + ADDR_W'(4);
            end
            if (q.beats != '1) begin
                d.beats = q.beats + CNT_W'(1);
            end
        end
    end

    assign first_beat = (q.beats == '0);
    assign page_last  = !q.wrap && (&q.addr[PAGE_BITS-1:2]);
    assign line_last  = q.wrap && (q.beats == CNT_W'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: a wrapping burst never leaves its line
    assert_wrap_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !load && q.wrap) |=> (q.addr[ADDR_W-1:LL] == $past(q.addr[ADDR_W-1:LL])));

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
    import pci_tgt_term_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PAGE_BITS   = 12,
    parameter int unsigned LINE_BYTES  = 32,
    parameter int unsigned FIRST_LIMIT = 32,
    parameter int unsigned NEXT_LIMIT  = 8,
    parameter int unsigned BEAT_CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic                irdy_n,
    input  logic                addr_hit,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                is_write,
    input  logic                buf_avail,
    input  logic                win_nonpref,
    input  logic                wrap_mode,
    input  logic                data_ready,
    input  logic                abort_req,
    input  logic                par_err,
    output logic                devsel_n,
    output logic                trdy_n,
    output logic                stop_n,
    output logic                wr_strobe,
    output logic                wr_cancel,
    output logic [STATUS_W-1:0] status
);

    ctl_s q, d;
    logic claim, beat;
    logic first_beat, page_last, line_last;
    logic expired, tmr_run, tmr_clear, disc_hit;

    assign claim     = (q.st == ST_IDLE) && addr_hit && !frame_n;
    assign beat      = (q.st == ST_XFER) && q.trdy && !irdy_n;
    assign tmr_run   = (q.st == ST_XFER) && !q.trdy && !data_ready;
    assign tmr_clear = claim || beat;
    assign disc_hit  = q.np || page_last || line_last;

    ptt_wait_timer #(
        .FIRST_LIMIT (FIRST_LIMIT),
        .NEXT_LIMIT  (NEXT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .first   (first_beat),
        .expired (expired)
    );

    ptt_burst_track #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .LINE_BYTES (LINE_BYTES),
        .CNT_W      (BEAT_CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (claim),
        .load_addr  (addr),
        .load_wrap  (wrap_mode && is_write),
        .beat       (beat),
        .first_beat (first_beat),
        .page_last  (page_last),
        .line_last  (line_last)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (claim) begin
                    d.wr     = is_write;
                    d.np     = win_nonpref;
                    d.cancel = par_err && is_write;
                    d.devsel = 1'b1;
                    d.trdy   = 1'b0;
                    if (abort_req) begin
                        d.devsel = 1'b0;
                        d.stop   = 1'b1;
                        d.sig_ta = 1'b1;
                        d.st     = ST_STOP;
                    end else if (!buf_avail) begin
                        d.stop = 1'b1;
                        d.st   = ST_STOP;
                    end else begin
                        d.st = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (par_err && q.wr) begin
                    d.cancel = 1'b1;
                end
                if (abort_req) begin
                    d.devsel = 1'b0;
                    d.trdy   = 1'b0;
                    d.stop   = 1'b1;
                    d.sig_ta = 1'b1;
                    d.st     = ST_STOP;
                end else if (beat) begin
                    if (frame_n) begin
                        d.devsel = 1'b0;
                        d.trdy   = 1'b0;
                        d.cancel = 1'b0;
                        d.st     = ST_IDLE;
                    end else if (disc_hit) begin
                        d.trdy = 1'b0;
                        d.stop = 1'b1;
                        d.st   = ST_STOP;
                    end else begin
                        d.trdy = data_ready;
                    end
                end else if (!q.trdy && data_ready) begin
                    d.trdy = 1'b1;
                end else if (expired) begin
                    d.stop = 1'b1;
                    d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (frame_n) begin
                    d.devsel = 1'b0;
                    d.trdy   = 1'b0;
                    d.stop   = 1'b0;
                    d.cancel = 1'b0;
                    d.st     = ST_IDLE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign devsel_n  = !q.devsel;
    assign trdy_n    = !q.trdy;
    assign stop_n    = !q.stop;
    assign wr_strobe = beat && q.wr && !q.cancel && !par_err;
    assign wr_cancel = q.cancel;

    always_comb begin
        status             = '0;
        status[SIG_TA_BIT] = q.sig_ta;
    end

    // R2: a clean claim raises DEVSEL without STOP
    assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && buf_avail && !abort_req) |=> (q.devsel && !q.stop && !q.trdy));

    // R3: retry or disconnect never carries TRDY
    assert_stop_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.stop) && q.devsel) |-> !q.trdy);

    // R9: an abort on the pins always has its status flag
    assert_abort_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stop && !q.devsel) |-> status[SIG_TA_BIT]);

    // R10: abort wins over a missing buffer
    assert_abort_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && abort_req) |=> (q.stop && !q.devsel));

    // R11: release one clock after FRAME# rises
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stop && frame_n) |=> (!q.stop && !q.devsel && !q.trdy));

    // R12: a cancelled write stays cancelled until the transaction ends
    assert_cancel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cancel && (q.st != ST_IDLE)) |=> (q.cancel || (q.st == ST_IDLE)));

endmodule

// File: tb/sim_pci_tgt_term.sv
`timescale 1ns/1ps
module sim_pci_tgt_term;

    localparam int K_NORM  = 0;
    localparam int K_DISC  = 1;
    localparam int K_RETRY = 2;
    localparam int K_ABORT = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        np;
        logic        wrap;
        logic        bfree;
        logic [7:0]  maxb;
        logic [7:0]  stall;
        logic [7:0]  par;
        logic [7:0]  abrt;
        logic [7:0]  xbeats;
        logic [7:0]  xgap;
        logic [1:0]  xkind;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    // addr, wr, np, wrap, bfree, maxb, stall, par, abrt, xbeats, xgap, xkind, req
    localparam vec_t VEC [NV] = '{
        '{32'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'hFF, 8'hFF, 8'hFF, 8'd4,  8'hFF, 2'd0, 8'd2},  // R2 read
        '{32'h2000, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3,  8'hFF, 8'hFF, 8'hFF, 8'd3,  8'hFF, 2'd0, 8'd13}, // R13 write
        '{32'h1FF8, 1'b1, 1'b0, 1'b0, 1'b1, 8'd6,  8'hFF, 8'hFF, 8'hFF, 8'd2,  8'hFF, 2'd1, 8'd6},  // R6 page end
        '{32'h3FFC, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'hFF, 8'hFF, 8'hFF, 8'd1,  8'hFF, 2'd1, 8'd6},  // R6 last word
        '{32'h1FFC, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  8'hFF, 8'hFF, 8'hFF, 8'd1,  8'hFF, 2'd0, 8'd6},  // R6 final beat
        '{32'h0100, 1'b0, 1'b1, 1'b0, 1'b1, 8'd4,  8'hFF, 8'hFF, 8'hFF, 8'd1,  8'hFF, 2'd1, 8'd7},  // R7 nonpref
        '{32'h4008, 1'b1, 1'b0, 1'b1, 1'b1, 8'd12, 8'hFF, 8'hFF, 8'hFF, 8'd8,  8'hFF, 2'd1, 8'd8},  // R8 wrap write
        '{32'h4008, 1'b0, 1'b0, 1'b1, 1'b1, 8'd12, 8'hFF, 8'hFF, 8'hFF, 8'd12, 8'hFF, 2'd0, 8'd8},  // R8 wrap read
        '{32'h1FF0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 8'hFF, 8'hFF, 8'hFF, 8'd8,  8'hFF, 2'd1, 8'd8},  // R8 no page stop
        '{32'h6000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  8'hFF, 8'hFF, 8'hFF, 8'd0,  8'd0,  2'd2, 8'd3},  // R3 no buffer
        '{32'h6000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4,  8'd0,  8'hFF, 8'hFF, 8'd0,  8'd32, 2'd2, 8'd4},  // R4 latency
        '{32'h5000, 1'b1, 1'b0, 1'b0, 1'b1, 8'd6,  8'd2,  8'hFF, 8'hFF, 8'd2,  8'd8,  2'd1, 8'd5},  // R5 wait limit
        '{32'h7000, 1'b1, 1'b0, 1'b0, 1'b0, 8'd4,  8'hFF, 8'hFF, 8'd0,  8'd0,  8'd0,  2'd3, 8'd10}, // R10 priority
        '{32'h7100, 1'b1, 1'b0, 1'b0, 1'b1, 8'd6,  8'hFF, 8'hFF, 8'd2,  8'd2,  8'd0,  2'd3, 8'd9},  // R9 abort
        '{32'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 8'd4,  8'hFF, 8'd2,  8'hFF, 8'd4,  8'hFF, 2'd0, 8'd12}, // R12 parity
        '{32'h0200, 1'b1, 1'b1, 1'b0, 1'b1, 8'd1,  8'hFF, 8'hFF, 8'hFF, 8'd1,  8'hFF, 2'd0, 8'd7},  // R7 single final
        '{32'h4000, 1'b1, 1'b0, 1'b1, 1'b1, 8'd8,  8'hFF, 8'hFF, 8'hFF, 8'd8,  8'hFF, 2'd0, 8'd8}   // R8 final on line end
    };

    logic        clk = 1'b0;
    logic        rst_n, frame_n, irdy_n, addr_hit, is_write, buf_avail;
    logic        win_nonpref, wrap_mode, data_ready, abort_req, par_err;
    logic [31:0] addr;
    logic        devsel_n, trdy_n, stop_n, wr_strobe, wr_cancel;
    logic [15:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pci_tgt_term u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .addr_hit(addr_hit), .addr(addr), .is_write(is_write),
        .buf_avail(buf_avail), .win_nonpref(win_nonpref), .wrap_mode(wrap_mode),
        .data_ready(data_ready), .abort_req(abort_req), .par_err(par_err),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .wr_strobe(wr_strobe), .wr_cancel(wr_cancel), .status(status)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_bus();
        frame_n = 1'b1; irdy_n = 1'b1; addr_hit = 1'b0; data_ready = 1'b0;
        abort_req = 1'b0; par_err = 1'b0;
    endtask

    task automatic run_txn(input vec_t v, input string req, output int beats, output int kind,
                           output int gap, output int strobes, output bit saw_cancel);
        int  idle;
        bit  last;
        beats = 0; kind = -1; gap = -1; strobes = 0; saw_cancel = 1'b0; idle = 0;
        @(negedge clk);
        addr = v.addr; is_write = v.wr; win_nonpref = v.np; wrap_mode = v.wrap;
        buf_avail = v.bfree; frame_n = 1'b0; addr_hit = 1'b1;
        data_ready = (v.stall != 8'd0); abort_req = (v.abrt == 8'd0);
        @(negedge clk);
        addr_hit = 1'b0; abort_req = 1'b0; irdy_n = 1'b0;
        if (v.abrt != 8'd0 && v.bfree) begin
            chk("R2", "devsel_n after claim", int'(devsel_n), 0);
            chk("R2", "trdy_n after claim", int'(trdy_n), 1);
        end
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (wr_cancel) saw_cancel = 1'b1;
            if (!stop_n) begin
                kind = devsel_n ? K_ABORT : ((beats == 0) ? K_RETRY : K_DISC);
                gap  = idle;
                chk(req, "trdy_n while stop", int'(trdy_n), 1);
                frame_n = 1'b0;
                for (int h = 0; h < 2; h++) begin
                    @(negedge clk);
                    chk("R11", "stop_n held while frame low", int'(stop_n), 0);
                end
                frame_n = 1'b1;
                @(negedge clk);
                chk("R11", "release after frame high",
                    int'({devsel_n, trdy_n, stop_n}), 7);
                chk("R12", "cancel cleared at end", int'(wr_cancel), 0);
                irdy_n = 1'b1;
                break;
            end
            frame_n = (beats + 1 >= int'(v.maxb));
            if (!trdy_n) begin
                beats++;
                if (int'(v.abrt) == beats) abort_req = 1'b1;
                if (int'(v.par) == beats) par_err = 1'b1;
                if (int'(v.stall) == beats) data_ready = 1'b0;
                #1;
                if (wr_strobe) strobes++;
                last = frame_n;
                @(negedge clk);
                abort_req = 1'b0; par_err = 1'b0; idle = 0;
                if (last && kind < 0 && stop_n) begin
                    kind = K_NORM;
                    chk("R2", "release after final beat",
                        int'({devsel_n, trdy_n, stop_n}), 7);
                    chk("R12", "cancel cleared at end", int'(wr_cancel), 0);
                    irdy_n = 1'b1;
                    break;
                end
            end else begin
                @(negedge clk);
                idle++;
            end
        end
        idle_bus();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  beats, kind, gap, strobes;
        bit  saw;
        int  xstr;
        string tag;
        rst_n = 1'b0; addr = '0; is_write = 1'b0; buf_avail = 1'b1;
        win_nonpref = 1'b0; wrap_mode = 1'b0;
        idle_bus();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pins after reset", int'({devsel_n, trdy_n, stop_n}), 7);
        chk("R1", "strobe and cancel after reset", int'({wr_strobe, wr_cancel}), 0);
        chk("R1", "status after reset", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d", VEC[i].req);
            run_txn(VEC[i], tag, beats, kind, gap, strobes, saw);
            chk(tag, $sformatf("vector %0d beats", i), beats, int'(VEC[i].xbeats));
            chk(tag, $sformatf("vector %0d termination", i), kind, int'(VEC[i].xkind));
            if (VEC[i].xgap != 8'hFF)
                chk(tag, $sformatf("vector %0d edges to stop", i), gap, int'(VEC[i].xgap));
            xstr = !VEC[i].wr ? 0 : ((VEC[i].par != 8'hFF) ? int'(VEC[i].par) - 1 : int'(VEC[i].xbeats));
            chk("R13", $sformatf("vector %0d write strobes", i), strobes, xstr);
            chk("R12", $sformatf("vector %0d cancel seen", i), int'(saw),
                int'(VEC[i].wr && VEC[i].par != 8'hFF));
        end

        // R9 sticky status flag at bit 11 only
        chk("R9", "status after aborts", int'(status), 16'h0800);
        repeat (4) @(negedge clk);
        chk("R9", "status still held", int'(status), 16'h0800);

        // R1 reset clears the flag again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "status after second reset", int'(status), 0);
        chk("R1", "pins after second reset", int'({devsel_n, trdy_n, stop_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule